// File: doc/BRIEF.md
# Precise exception controller

This block is the control slice that keeps exceptions precise in a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. Each instruction carries a 2-bit status code and two program counters: its own address and the address of the instruction after it. Fetch classifies the instruction it delivers. The memory stage can mark a bad data address. Decode and execute pass the status on unchanged. A fault becomes an exception only when the faulting instruction reaches write-back. A fault on a wrong-path instruction that is squashed earlier therefore never has any effect.

While a faulting instruction sits in the memory or write-back stage, the block lowers the gates that allow the execute stage to update condition codes and the memory stage to write. Younger instructions therefore leave no trace, and the gates drop in the same cycle the fault becomes visible. When the exception is taken, the block flushes every younger stage. It also presents the resume address and a per-cause handler address, from which fetch restarts in the next cycle. A halt instruction stops the machine when it reaches write-back, and the machine stays stopped until reset.

Top module: `precise_exc_ctl`

## Requirements
- R1: Fetch encodes status as 00 normal, 01 halt, 10 bad address, 11 illegal opcode. A bad fetch address wins over an illegal opcode, and an illegal opcode wins over halt. The code reaches write-back unchanged and appears on `exc_cause` when the instruction is taken.
- R2: An instruction accepted by fetch in cycle t occupies write-back in cycle t+4. When its status is normal, `retire_ok` is high and `retire_pc` shows its PC in that cycle.
- R3: When `mem_addr_bad` is high while the memory stage holds a valid normal instruction, that instruction reaches write-back with status 10. An instruction that already carries a non-normal status keeps its code.
- R4: `cc_update_ok` is high only when execute holds a valid normal instruction and neither memory nor write-back holds a non-normal one. It falls in the same cycle the memory stage marks a fault.
- R5: `mem_write_ok` is high only when memory holds a valid instruction whose status is normal after the data-address check and write-back holds no non-normal instruction.
- R6: `exc_take` is high exactly when write-back holds a valid instruction with status 10 or 11. In that cycle `fetch_redirect_pc` equals HANDLER_BASE + code × HANDLER_STRIDE.
- R7: `exc_resume_pc` is the faulting instruction's own PC when RESUME_NEXT = 0, and its next PC when RESUME_NEXT = 1.
- R8: Taking an exception turns every younger stage into a bubble, and the fetch input in that cycle is dropped. Nothing retires or faults in the following cycles until new instructions arrive.
- R9: `mispredict` turns the decode and execute stages into bubbles at the next edge. A squashed fault never raises an exception, and the older instruction in execute still retires.
- R10: A halt in write-back raises no exception and sets `halted` one cycle later. `halted` stays high until reset, and while it is high nothing retires and both side-effect gates stay low.
- R11: After reset every stage is empty and `retire_ok`, `exc_take`, `halted`, `cc_update_ok` and `mem_write_ok` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetch delivers an instruction this cycle |
| f_pc | input | PC_W | Address of the fetched instruction |
| f_next_pc | input | PC_W | Address of the instruction that follows it |
| f_addr_bad | input | 1 | Fetch address was invalid |
| f_illegal | input | 1 | Instruction code is not recognised |
| f_halt | input | 1 | Instruction is a halt |
| mem_addr_bad | input | 1 | Data address of the memory-stage instruction is invalid |
| mispredict | input | 1 | Squash decode and execute at the next edge |
| cc_update_ok | output | 1 | Execute may update condition codes |
| mem_write_ok | output | 1 | Memory stage may write |
| exc_take | output | 1 | Exception taken this cycle |
| exc_cause | output | 2 | Status code of the taken exception |
| exc_resume_pc | output | PC_W | Resume address for the handler |
| fetch_redirect_pc | output | PC_W | Handler address for fetch to use next cycle |
| halted | output | 1 | Machine stopped by a halt |
| retire_ok | output | 1 | Normal instruction completes in write-back |
| retire_pc | output | PC_W | PC of the write-back instruction |

## Verification
The bench builds two copies with PC_W = 16, HANDLER_BASE = 0x0100 and HANDLER_STRIDE = 0x0020. The two copies differ only in RESUME_NEXT, which is 0 in one and 1 in the other, and both are driven by the same stimulus. This lets a single faulting instruction show both resume conventions in the same cycle, and it gives distinct handler addresses (0x140, 0x160) for the two exception causes. MP_DEPTH keeps its default of 2, so a mispredict squashes exactly decode and execute. A fault planted in decode then shows that a squashed fault cannot reach write-back.

// File: rtl/precise_exc_pkg.sv
package precise_exc_pkg;

   // Status code carried beside every instruction; bit 1 marks a true fault.
   typedef enum logic [1:0] {
      ST_AOK = 2'b00,
      ST_HLT = 2'b01,
      ST_ADR = 2'b10,
      ST_INS = 2'b11
   } stat_e;

   function automatic logic is_fault(stat_e s);
      return s[1];
   endfunction

   function automatic logic not_normal(stat_e s);
      return s != ST_AOK;
   endfunction

endpackage

// File: rtl/fetch_classify.sv
module fetch_classify
   import precise_exc_pkg::*;
(
   input  logic  in_valid,
   input  logic  addr_bad,
   input  logic  illegal,
   input  logic  halt,
   output logic  out_valid,
   output stat_e out_status
);

   // Priority: an unreadable address makes the opcode meaningless,
   // and an illegal opcode cannot be a halt.
   always_comb begin
      out_valid  = in_valid;
      out_status = ST_AOK;
      if (in_valid) begin
         if (addr_bad)
            out_status = ST_ADR;
         else if (illegal)
            out_status = ST_INS;
         else if (halt)
            out_status = ST_HLT;
         else
            out_status = ST_AOK;
      end
   end

endmodule

// File: rtl/pipe_stage.sv
module pipe_stage
   import precise_exc_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kill,
   input  logic            i_valid,
   input  stat_e           i_st,
   input  logic [PC_W-1:0] i_pc,
   input  logic [PC_W-1:0] i_npc,
   output logic            o_valid,
   output stat_e           o_st,
   output logic [PC_W-1:0] o_pc,
   output logic [PC_W-1:0] o_npc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_st    <= ST_AOK;
         o_pc    <= '0;
         o_npc   <= '0;
      end else if (kill) begin
         // Bubble: a squashed fault is erased together with the instruction.
         o_valid <= 1'b0;
         o_st    <= ST_AOK;
         o_pc    <= '0;
         o_npc   <= '0;
      end else begin
         o_valid <= i_valid;
         o_st    <= i_valid ? i_st : ST_AOK;
         o_pc    <= i_pc;
         o_npc   <= i_npc;
      end
   end

   // R9: an empty slot never carries a fault code
   a_r9_bubble_clean: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> (o_st == ST_AOK));

endmodule

// File: rtl/exc_gate.sv
module exc_gate
   import precise_exc_pkg::*;
#(
   parameter int              PC_W           = 32,
   parameter logic [PC_W-1:0] HANDLER_BASE   = '0,
   parameter logic [PC_W-1:0] HANDLER_STRIDE = 'h40,
   parameter int              RESUME_NEXT    = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            e_valid,
   input  stat_e           e_st,
   input  logic            m_valid,
   input  stat_e           m_st,
   input  logic            w_valid,
   input  stat_e           w_st,
   input  logic [PC_W-1:0] w_pc,
   input  logic [PC_W-1:0] w_npc,
   output logic            cc_ok,
   output logic            mem_wr_ok,
   output logic            exc_take,
   output logic [1:0]      exc_cause,
   output logic [PC_W-1:0] resume_pc,
   output logic [PC_W-1:0] redirect_pc,
   output logic            wb_stop,
   output logic            halted,
   output logic            retire_ok
);

   localparam int NCODE = 4;

   logic            m_bad, w_bad, halt_hit;
   logic [PC_W-1:0] hvec [NCODE];

   // One handler entry per status code, indexed by the code itself.
   for (genvar c = 0; c < NCODE; c++) begin : g_hvec
      assign hvec[c] = HANDLER_BASE + PC_W'(c) * HANDLER_STRIDE;
   end

   assign m_bad    = m_valid && not_normal(m_st);
   assign w_bad    = w_valid && not_normal(w_st);
   assign halt_hit = w_valid && (w_st == ST_HLT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         halted <= 1'b0;
      else if (halt_hit)
         halted <= 1'b1;
   end

   always_comb begin
      cc_ok     = e_valid && !not_normal(e_st) && !m_bad && !w_bad && !halted;
      mem_wr_ok = m_valid && !not_normal(m_st) && !w_bad && !halted;
      exc_take  = w_valid && is_fault(w_st) && !halted;
      exc_cause = exc_take ? w_st : ST_AOK;
      wb_stop   = w_bad || halted;
      retire_ok = w_valid && !not_normal(w_st) && !halted;
   end

   assign resume_pc   = (RESUME_NEXT != 0) ? w_npc : w_pc;
   assign redirect_pc = hvec[w_st];

   // R10: a halted machine stays halted until reset
   a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R10: nothing completes and no side effect is allowed once halted
   a_r10_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!retire_ok && !exc_take && !cc_ok && !mem_wr_ok));

   // R10: a halt in write-back is not an exception
   a_r10_halt_no_exc: assert property (@(posedge clk) disable iff (!rst_n)
      halt_hit |-> !exc_take);

endmodule

// File: rtl/precise_exc_ctl.sv
module precise_exc_ctl
   import precise_exc_pkg::*;
#(
   parameter int              PC_W           = 32,
   parameter logic [PC_W-1:0] HANDLER_BASE   = 'h0000_1000,
   parameter logic [PC_W-1:0] HANDLER_STRIDE = 'h40,
   parameter int              RESUME_NEXT    = 0,
   parameter int              MP_DEPTH       = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            f_valid,
   input  logic [PC_W-1:0] f_pc,
   input  logic [PC_W-1:0] f_next_pc,
   input  logic            f_addr_bad,
   input  logic            f_illegal,
   input  logic            f_halt,
   input  logic            mem_addr_bad,
   input  logic            mispredict,
   output logic            cc_update_ok,
   output logic            mem_write_ok,
   output logic            exc_take,
   output logic [1:0]      exc_cause,
   output logic [PC_W-1:0] exc_resume_pc,
   output logic [PC_W-1:0] fetch_redirect_pc,
   output logic            halted,
   output logic            retire_ok,
   output logic [PC_W-1:0] retire_pc
);

   // Slots: 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back.
   localparam int NSTG    = 4;
   localparam int S_EXE   = 2;
   localparam int S_MEM   = 3;
   localparam int S_WB    = NSTG;

   // Elaboration-time parameter checks.
   if (PC_W < 4) begin : g_chk_pcw
      $error("precise_exc_ctl: PC_W must be at least 4");
   end
   if (RESUME_NEXT != 0 && RESUME_NEXT != 1) begin : g_chk_res
      $error("precise_exc_ctl: RESUME_NEXT must be 0 or 1");
   end
   if (MP_DEPTH < 1 || MP_DEPTH > S_MEM) begin : g_chk_mp
      $error("precise_exc_ctl: MP_DEPTH must lie in 1..3");
   end
   if (HANDLER_STRIDE == '0) begin : g_chk_stride
      $error("precise_exc_ctl: HANDLER_STRIDE must be nonzero");
   end

   logic            s_v   [0:NSTG];
   stat_e           s_st  [0:NSTG];
   logic [PC_W-1:0] s_pc  [0:NSTG];
   logic [PC_W-1:0] s_npc [0:NSTG];

   logic            in_v   [1:NSTG];
   stat_e           in_st  [1:NSTG];
   logic [PC_W-1:0] in_pc  [1:NSTG];
   logic [PC_W-1:0] in_npc [1:NSTG];

   stat_e m_st_post;
   logic  wb_stop;

   fetch_classify u_fetch (
      .in_valid   (f_valid),
      .addr_bad   (f_addr_bad),
      .illegal    (f_illegal),
      .halt       (f_halt),
      .out_valid  (s_v[0]),
      .out_status (s_st[0])
   );
   assign s_pc[0]  = f_pc;
   assign s_npc[0] = f_next_pc;

   // Memory stage: mark a bad data address, keep any older cause.
   assign m_st_post = (s_v[S_MEM] && (s_st[S_MEM] == ST_AOK) && mem_addr_bad)
                      ? ST_ADR : s_st[S_MEM];

   for (genvar k = 1; k <= NSTG; k++) begin : g_stg
      logic kill_k;

      if (k == S_WB) begin : g_from_mem
         assign in_v[k]   = s_v[k-1];
         assign in_st[k]  = m_st_post;
         assign in_pc[k]  = s_pc[k-1];
         assign in_npc[k] = s_npc[k-1];
      end else begin : g_plain
         assign in_v[k]   = s_v[k-1];
         assign in_st[k]  = s_st[k-1];
         assign in_pc[k]  = s_pc[k-1];
         assign in_npc[k] = s_npc[k-1];
      end

      if (k <= MP_DEPTH) begin : g_mp_kill
         assign kill_k = wb_stop || mispredict;
      end else begin : g_wb_kill
         assign kill_k = wb_stop;
      end

      pipe_stage #(.PC_W(PC_W)) u_stg (
         .clk     (clk),
         .rst_n   (rst_n),
         .kill    (kill_k),
         .i_valid (in_v[k]),
         .i_st    (in_st[k]),
         .i_pc    (in_pc[k]),
         .i_npc   (in_npc[k]),
         .o_valid (s_v[k]),
         .o_st    (s_st[k]),
         .o_pc    (s_pc[k]),
         .o_npc   (s_npc[k])
      );
   end

   exc_gate #(
      .PC_W           (PC_W),
      .HANDLER_BASE   (HANDLER_BASE),
      .HANDLER_STRIDE (HANDLER_STRIDE),
      .RESUME_NEXT    (RESUME_NEXT)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .e_valid     (s_v[S_EXE]),
      .e_st        (s_st[S_EXE]),
      .m_valid     (s_v[S_MEM]),
      .m_st        (m_st_post),
      .w_valid     (s_v[S_WB]),
      .w_st        (s_st[S_WB]),
      .w_pc        (s_pc[S_WB]),
      .w_npc       (s_npc[S_WB]),
      .cc_ok       (cc_update_ok),
      .mem_wr_ok   (mem_write_ok),
      .exc_take    (exc_take),
      .exc_cause   (exc_cause),
      .resume_pc   (exc_resume_pc),
      .redirect_pc (fetch_redirect_pc),
      .wb_stop     (wb_stop),
      .halted      (halted),
      .retire_ok   (retire_ok)
   );

   assign retire_pc = s_pc[S_WB];

   // R3: a bad data address on a normal instruction arrives in write-back as ADR
   a_r3_mem_marks_adr: assert property (@(posedge clk) disable iff (!rst_n)
      (s_v[S_MEM] && (s_st[S_MEM] == ST_AOK) && mem_addr_bad && !wb_stop)
      |=> (s_v[S_WB] && (s_st[S_WB] == ST_ADR)));

   // R4 / R5: while an exception is taken no younger side effect is allowed
   a_r4_exc_blocks_effects: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |-> (!cc_update_ok && !mem_write_ok));

   // R8: the cycle after an exception, write-back is empty
   a_r8_flush_after_exc: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> (!exc_take && !retire_ok));

   // R9: a mispredict empties decode and the deepest squashed stage
   a_r9_squash: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |=> (!s_v[1] && !s_v[MP_DEPTH]));

endmodule

// File: tb/sim_precise_exc_ctl.sv
module sim_precise_exc_ctl;

   localparam int PC_W = 16;
   localparam logic [PC_W-1:0] HBASE   = 16'h0100;
   localparam logic [PC_W-1:0] HSTRIDE = 16'h0020;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            f_valid, f_addr_bad, f_illegal, f_halt, mem_addr_bad, mispredict;
   logic [PC_W-1:0] f_pc, f_next_pc;

   logic            cc0, mw0, ex0, hl0, rt0;
   logic [1:0]      cause0;
   logic [PC_W-1:0] res0, redir0, rpc0;
   logic            cc1, mw1, ex1, hl1, rt1;
   logic [1:0]      cause1;
   logic [PC_W-1:0] res1, redir1, rpc1;

   int n_chk = 0;
   int n_err = 0;

   precise_exc_ctl #(.PC_W(PC_W), .HANDLER_BASE(HBASE), .HANDLER_STRIDE(HSTRIDE),
                     .RESUME_NEXT(0)) u0 (
      .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc), .f_next_pc(f_next_pc),
      .f_addr_bad(f_addr_bad), .f_illegal(f_illegal), .f_halt(f_halt),
      .mem_addr_bad(mem_addr_bad), .mispredict(mispredict),
      .cc_update_ok(cc0), .mem_write_ok(mw0), .exc_take(ex0), .exc_cause(cause0),
      .exc_resume_pc(res0), .fetch_redirect_pc(redir0), .halted(hl0),
      .retire_ok(rt0), .retire_pc(rpc0));

   precise_exc_ctl #(.PC_W(PC_W), .HANDLER_BASE(HBASE), .HANDLER_STRIDE(HSTRIDE),
                     .RESUME_NEXT(1)) u1 (
      .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc), .f_next_pc(f_next_pc),
      .f_addr_bad(f_addr_bad), .f_illegal(f_illegal), .f_halt(f_halt),
      .mem_addr_bad(mem_addr_bad), .mispredict(mispredict),
      .cc_update_ok(cc1), .mem_write_ok(mw1), .exc_take(ex1), .exc_cause(cause1),
      .exc_resume_pc(res1), .fetch_redirect_pc(redir1), .halted(hl1),
      .retire_ok(rt1), .retire_pc(rpc1));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_in();
      f_valid = 0; f_pc = '0; f_next_pc = '0;
      f_addr_bad = 0; f_illegal = 0; f_halt = 0;
      mem_addr_bad = 0; mispredict = 0;
   endtask

   task automatic next_cycle();
      @(negedge clk);
      idle_in();
   endtask

   task automatic put(input logic [PC_W-1:0] pc, input logic bad,
                      input logic ill, input logic hlt);
      f_valid = 1; f_pc = pc; f_next_pc = pc + 16'd4;
      f_addr_bad = bad; f_illegal = ill; f_halt = hlt;
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) next_cycle();
   endtask

   task automatic t_reset();
      #1;
      check("R11", "retire_ok", rt0, 0);
      check("R11", "exc_take", ex0, 0);
      check("R11", "halted", hl0, 0);
      check("R11", "cc_update_ok", cc0, 0);
      check("R11", "mem_write_ok", mw0, 0);
   endtask

   task automatic t_normal();
      next_cycle(); put(16'h0010, 0, 0, 0); #1;                       // c0
      next_cycle(); put(16'h0014, 0, 0, 0); #1;                       // c1
      next_cycle(); put(16'h0018, 0, 0, 0); #1;                       // c2
      check("R4", "cc ok normal", cc0, 1);
      next_cycle(); #1;                                               // c3
      check("R5", "mem write ok normal", mw0, 1);
      check("R4", "cc ok with normal older", cc0, 1);
      next_cycle(); #1;                                               // c4
      check("R2", "retire first", rt0, 1);
      check("R2", "retire pc first", rpc0, 16'h0010);
      next_cycle(); #1;
      check("R2", "retire pc second", rpc0, 16'h0014);
      next_cycle(); #1;
      check("R2", "retire pc third", rpc0, 16'h0018);
      check("R2", "no exception", ex0, 0);
      drain(5);
   endtask

   task automatic t_mem_fault();
      next_cycle(); put(16'h0020, 0, 0, 0); #1;                       // c0
      next_cycle(); put(16'h0024, 0, 0, 0); #1;                       // c1
      next_cycle(); put(16'h0028, 0, 0, 0); #1;                       // c2
      next_cycle(); put(16'h002C, 0, 0, 0); mem_addr_bad = 1; #1;     // c3
      check("R5", "mem write blocked on own fault", mw0, 0);
      check("R4", "cc blocked same cycle", cc0, 0);
      next_cycle(); put(16'h0030, 0, 0, 0); #1;                       // c4
      check("R6", "exc taken", ex0, 1);
      check("R3", "cause ADR from memory", cause0, 2'b10);
      check("R6", "handler ADR", redir0, 16'h0140);
      check("R7", "resume own pc", res0, 16'h0020);
      check("R7", "resume next pc", res1, 16'h0024);
      check("R5", "younger mem write blocked", mw0, 0);
      check("R4", "younger cc blocked", cc0, 0);
      check("R2", "faulting does not retire", rt0, 0);
      for (int i = 0; i < 5; i++) begin
         next_cycle(); #1;
         check("R8", "no retire after flush", rt0, 0);
         check("R8", "no repeat exception", ex0, 0);
      end
      drain(2);
   endtask

   task automatic t_fetch_code(input logic [PC_W-1:0] pc, input logic bad,
                               input logic ill, input logic hlt,
                               input logic [1:0] code, input logic [PC_W-1:0] hnd);
      next_cycle(); put(pc, bad, ill, hlt); #1;
      drain(3);
      next_cycle(); #1;
      check("R1", "fetch status code", cause0, code);
      check("R6", "exc on fetch fault", ex0, 1);
      check("R6", "handler by code", redir0, hnd);
      check("R7", "resume own pc (fetch)", res0, pc);
      check("R7", "resume next pc (fetch)", res1, pc + 16'd4);
      drain(6);
   endtask

   task automatic t_mem_keeps();
      next_cycle(); put(16'h0060, 0, 1, 0); #1;
      drain(2);
      next_cycle(); mem_addr_bad = 1; #1;                             // c3
      next_cycle(); #1;                                               // c4
      check("R3", "older cause kept", cause0, 2'b11);
      check("R6", "handler INS", redir0, 16'h0160);
      drain(6);
   endtask

   task automatic t_mispredict();
      next_cycle(); put(16'h0070, 0, 0, 0); #1;                       // c0
      next_cycle(); put(16'h0074, 0, 1, 0); #1;                       // c1
      next_cycle(); put(16'h0078, 1, 0, 0); mispredict = 1; #1;       // c2
      next_cycle(); put(16'h0090, 0, 0, 0); #1;                       // c3
      check("R9", "no exc c3", ex0, 0);
      next_cycle(); #1;                                               // c4
      check("R9", "older branch retires", rt0, 1);
      check("R9", "older branch pc", rpc0, 16'h0070);
      next_cycle(); #1;                                               // c5
      check("R9", "squashed illegal no exc", ex0, 0);
      check("R9", "bubble no retire c5", rt0, 0);
      next_cycle(); #1;                                               // c6
      check("R9", "squashed bad addr no exc", ex0, 0);
      check("R9", "bubble no retire c6", rt0, 0);
      next_cycle(); #1;                                               // c7
      check("R9", "correct path retires", rpc0, 16'h0090);
      check("R9", "correct path retire ok", rt0, 1);
      drain(5);
   endtask

   task automatic t_halt();
      next_cycle(); put(16'h0080, 0, 0, 1); #1;                       // c0
      next_cycle(); put(16'h0084, 0, 0, 0); #1;                       // c1
      next_cycle(); #1;                                               // c2
      next_cycle(); #1;                                               // c3
      check("R4", "cc blocked behind halt", cc0, 0);
      next_cycle(); #1;                                               // c4
      check("R10", "halt is no exception", ex0, 0);
      check("R10", "halted not yet", hl0, 0);
      check("R5", "mem write blocked behind halt", mw0, 0);
      check("R1", "halt does not retire", rt0, 0);
      next_cycle(); put(16'h0088, 0, 0, 0); #1;                       // c5
      check("R10", "halted set", hl0, 1);
      for (int i = 0; i < 6; i++) begin
         next_cycle(); put(16'h008C, 0, 0, 0); #1;
         check("R10", "halted holds", hl0, 1);
         check("R10", "nothing retires", rt0, 0);
      end
      next_cycle();
      rst_n = 0; #1;
      check("R11", "reset clears halted", hl0, 0);
      next_cycle(); rst_n = 1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      idle_in();
      rst_n = 0;
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk); rst_n = 1;
      t_normal();
      t_mem_fault();
      t_fetch_code(16'h0040, 0, 1, 0, 2'b11, 16'h0160);
      t_fetch_code(16'h0050, 1, 1, 1, 2'b10, 16'h0140);
      t_mem_keeps();
      t_mispredict();
      t_halt();
      t_normal();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule